// File: doc/BRIEF.md
# Control-Register Bus Handshake Master

This block turns one host request (a start pulse, a direction flag, a 16-bit address and 16-bit write data) into the full strobe/acknowledge sequence that a PHY's serial control-register bus expects. Each access is a chain of separate four-phase handshakes. A phase raises one strobe and waits for the acknowledge to go high. It then drops the strobe and waits for the acknowledge to go low. The address is always captured first. A read then strobes the read line and takes the returned word at the acknowledge. A write instead captures the data word and then raises the write strobe.

The PHY side is a single packed outbound word and a single packed inbound word, so the block connects straight to a register-style control interface. Every wait phase has a cycle limit taken from the host port. If the acknowledge does not reach the level the phase waits for within that limit, the access is abandoned: all strobes drop, and done is reported together with an error flag. Only one access runs at a time.

Top module: `cr_bus_master`

## Requirements
- R1: After reset, the outbound word, busy, done, err and read data are all zero.
- R2: The outbound word carries the bus value in bits 17:2, the write strobe in bit 0, the read strobe in bit 1, data capture in bit 18 and address capture in bit 19. The inbound word carries the returned value in bits 15:0 and the acknowledge in bit 16.
- R3: An access starts by driving the address with all strobes low for 2 cycles. It then adds address capture until the acknowledge is high, and then drives the address alone until the acknowledge is low.
- R4: A read then drives an all-zero word for 1 cycle and raises the read strobe, with the value field zero, until the acknowledge is high. It captures bits 15:0 of the inbound word at that edge, then drives zero until the acknowledge is low.
- R5: A write then drives the data with no strobe for 2 cycles. It adds data capture until the acknowledge is high, and then drives the data alone until the acknowledge is low.
- R6: After the data capture, a write drives the data alone for 1 cycle and adds the write strobe until the acknowledge is high. It then drives the data alone until the acknowledge is low, and done follows.
- R7: At most one strobe is high in any cycle, and each strobe rises only while the value field holds the value of the cycle before.
- R8: The limit input is sampled when an access is accepted. A value L means a wait phase may last max(L,1) cycles. If the awaited level has not arrived by then, the next cycle shows an all-zero word, busy low, and done and err both high.
- R9: A start while busy is ignored: the access in progress, and the address it captured, stay unchanged.
- R10: done is a one-cycle pulse in the first idle cycle after an access. err is high only together with done.
- R11: Read data changes only at the acknowledged read strobe. It stays stable through writes, aborted accesses and idle time.
- R12: Addresses and data from 0x0000 to 0xFFFF pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Register address |
| wdata_i | input | 16 | Write data |
| tmo_cyc_i | input | 16 | Cycle limit for each wait phase |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access finished (pulse) |
| err_o | output | 1 | Access aborted on timeout (with done) |
| rdata_o | output | 16 | Last value read |
| cr_out_o | output | 20 | Packed outbound bus word |
| cr_in_i | input | 17 | Packed inbound word (value, acknowledge) |

## Verification
The assertions assume the PHY is synchronous to clk_i and changes the inbound word only between edges. They also assume the acknowledge makes no demands in the idle state. The bench responder follows these rules. It moves the acknowledge only at the falling edge, raises it only while it sees a strobe and lowers it only after the strobes drop, with programmable delays. Separate modes hold the acknowledge permanently low or permanently high, and those modes drive the timeout paths.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_A_HOLD, ST_A_CAP, ST_A_REL,
    ST_R_ZERO, ST_R_STB, ST_R_REL,
    ST_D_HOLD, ST_D_CAP, ST_D_REL,
    ST_W_SET, ST_W_STB, ST_W_REL
  } cr_state_e;

  typedef enum logic [1:0] {SRC_ZERO, SRC_ADDR, SRC_DATA} cr_src_e;

  typedef struct packed {
    logic cap_a;
    logic cap_d;
    logic rd;
    logic wr;
  } cr_strobe_t;
endpackage

// File: rtl/cr_phase_ctr.sv
module cr_phase_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EW-1:0]    cnt_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  // cycles spent in the phase so far, including this one
  assign cnt_inc = {1'b0, cnt_q} + EW'(1);
  assign last_o  = cnt_inc >= {1'b0, lim_i};
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/cr_seq_fsm.sv
module cr_seq_fsm
  import cr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tmo_i,
  output cr_state_e        state_o,
  output logic             accept_o,
  output logic             cnt_clr_o,
  output logic             latch_rd_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  cr_state_e st_q, st_d;
  logic      fin, abort;
  logic      done_q, err_q;

  always_comb begin
    st_d  = st_q;
    fin   = 1'b0;
    abort = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_A_HOLD;
      ST_A_HOLD: if (cnt_i == HOLD_LAST) st_d = ST_A_CAP;
      ST_A_CAP:  if (ack_i) st_d = ST_A_REL;  else if (tmo_i) abort = 1'b1;
      ST_A_REL:  if (!ack_i) st_d = wr_i ? ST_D_HOLD : ST_R_ZERO;
                 else if (tmo_i) abort = 1'b1;
      ST_R_ZERO: st_d = ST_R_STB;
      ST_R_STB:  if (ack_i) st_d = ST_R_REL;  else if (tmo_i) abort = 1'b1;
      ST_R_REL:  if (!ack_i) fin = 1'b1;      else if (tmo_i) abort = 1'b1;
      ST_D_HOLD: if (cnt_i == HOLD_LAST) st_d = ST_D_CAP;
      ST_D_CAP:  if (ack_i) st_d = ST_D_REL;  else if (tmo_i) abort = 1'b1;
      ST_D_REL:  if (!ack_i) st_d = ST_W_SET; else if (tmo_i) abort = 1'b1;
      ST_W_SET:  st_d = ST_W_STB;
      ST_W_STB:  if (ack_i) st_d = ST_W_REL;  else if (tmo_i) abort = 1'b1;
      ST_W_REL:  if (!ack_i) fin = 1'b1;      else if (tmo_i) abort = 1'b1;
      default:   abort = 1'b1;
    endcase
    if (fin || abort) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin || abort;
      err_q  <= abort;
    end
  end

  assign state_o    = st_q;
  assign accept_o   = (st_q == ST_IDLE) && start_i;
  assign cnt_clr_o  = st_d != st_q;
  assign latch_rd_o = (st_q == ST_R_STB) && ack_i;
  assign done_o     = done_q;
  assign err_o      = err_q;
endmodule

// File: rtl/cr_word_pack.sv
module cr_word_pack
  import cr_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int OUT_W = DATA_W + 4
) (
  input  cr_state_e         state_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [OUT_W-1:0]  word_o
);
  cr_src_e           src;
  cr_strobe_t        stb;
  logic [DATA_W-1:0] val;

  always_comb begin
    src = SRC_ZERO;
    stb = '0;
    unique case (state_i)
      ST_A_HOLD, ST_A_REL:           src = SRC_ADDR;
      ST_A_CAP:  begin src = SRC_ADDR; stb.cap_a = 1'b1; end
      ST_R_STB:                      stb.rd = 1'b1;
      ST_D_HOLD, ST_D_REL,
      ST_W_SET,  ST_W_REL:           src = SRC_DATA;
      ST_D_CAP:  begin src = SRC_DATA; stb.cap_d = 1'b1; end
      ST_W_STB:  begin src = SRC_DATA; stb.wr = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    unique case (src)
      SRC_ADDR: val = addr_i;
      SRC_DATA: val = data_i;
      default:  val = '0;
    endcase
  end

  // bit order is fixed by the PHY decoder
  assign word_o = {stb.cap_a, stb.cap_d, val, stb.rd, stb.wr};
endmodule

// File: rtl/cr_bus_master.sv
module cr_bus_master
  import cr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int HOLD_CYC = 2,
  localparam int OUT_W   = DATA_W + 4,
  localparam int IN_W    = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  tmo_cyc_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [OUT_W-1:0]  cr_out_o,
  input  logic [IN_W-1:0]   cr_in_i
);
  cr_state_e         state;
  logic              accept, cnt_clr, latch_rd, tmo;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
  logic [CNT_W-1:0]  lim_q;
  logic              wr_q;
  logic              ack;

  assign ack = cr_in_i[DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      lim_q   <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      lim_q   <= tmo_cyc_i;
      wr_q    <= wr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (latch_rd) rdata_q <= cr_in_i[DATA_W-1:0];
  end

  cr_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .lim_i  (lim_q),
    .cnt_o  (cnt),
    .last_o (tmo)
  );

  cr_seq_fsm #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .wr_i       (wr_q),
    .ack_i      (ack),
    .cnt_i      (cnt),
    .tmo_i      (tmo),
    .state_o    (state),
    .accept_o   (accept),
    .cnt_clr_o  (cnt_clr),
    .latch_rd_o (latch_rd),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  cr_word_pack #(.DATA_W(DATA_W)) u_pack (
    .state_i (state),
    .addr_i  (addr_q),
    .data_i  (wdata_q),
    .word_o  (cr_out_o)
  );

  assign busy_o  = state != ST_IDLE;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/cr_bus_master_chk.sv
module cr_bus_master_chk #(
  parameter int DATA_W = 16,
  localparam int OUT_W = DATA_W + 4,
  localparam int IN_W  = DATA_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [OUT_W-1:0]  cr_out_o,
  input logic [IN_W-1:0]   cr_in_i
);
  logic [3:0]        stb;
  logic [DATA_W-1:0] val;
  assign stb = {cr_out_o[OUT_W-1], cr_out_o[OUT_W-2], cr_out_o[1], cr_out_o[0]};
  assign val = cr_out_o[DATA_W+1:2];

  // R7
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb));
  // R3
  addr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cr_out_o[OUT_W-1]) |-> $stable(val));
  // R5
  data_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cr_out_o[OUT_W-2]) |-> $stable(val));
  // R6
  write_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cr_out_o[0]) |-> $stable(val));
  // R4
  read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_out_o[1] |-> (val == '0));
  // R8
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && cr_out_o == '0));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(rdata_o));
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (stb == '0));
endmodule

bind cr_bus_master cr_bus_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .rdata_o  (rdata_o),
  .cr_out_o (cr_out_o),
  .cr_in_i  (cr_in_i)
);

// File: tb/sim_cr_bus_master.sv
module sim_cr_bus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] tmo = 16'd50;
  logic        busy, done, err;
  logic [15:0] rdata;
  logic [19:0] cr_out;
  logic [16:0] cr_in;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cr_bus_master u0 (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .wr_i (wr),
    .addr_i (addr), .wdata_i (wdata), .tmo_cyc_i (tmo),
    .busy_o (busy), .done_o (done), .err_o (err), .rdata_o (rdata),
    .cr_out_o (cr_out), .cr_in_i (cr_in)
  );

  function automatic int phy_val(int a);
    return (a ^ 16'hA5C3) & 16'hFFFF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PHY responder
  int  mode = 0;  // 0 normal, 1 never ack, 2 ack stuck high
  int  dly_r = 0, dly_f = 0, rc = 0;
  bit  ack = 1'b0;
  int  cap_addr = 0, cap_data = 0, commit = -1, commits = 0;
  assign cr_in = {ack, 16'(phy_val(cap_addr))};

  // reference model
  int  q_word[$], q_kind[$], q_n[$];
  bit  m_idle = 1'b1;
  int  m_ph = 0, m_cnt = 0, m_lim = 0, m_addr = 0;
  bit  m_done = 1'b0, m_err = 1'b0;
  int  m_rdata = 0;

  task automatic push(int w, int k, int n);
    q_word.push_back(w); q_kind.push_back(k); q_n.push_back(n);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idle = 1; m_done = 0; m_err = 0; m_rdata = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (m_idle) begin
        if (start) begin
          q_word.delete(); q_kind.delete(); q_n.delete();
          m_addr = int'(addr); m_lim = int'(tmo);
          push(m_addr << 2, 0, 2);
          push((m_addr << 2) | (1 << 19), 1, 0);
          push(m_addr << 2, 2, 0);
          if (!wr) begin
            push(0, 0, 1); push(2, 3, 0); push(0, 2, 0);
          end else begin
            push(int'(wdata) << 2, 0, 2);
            push((int'(wdata) << 2) | (1 << 18), 1, 0);
            push(int'(wdata) << 2, 2, 0);
            push(int'(wdata) << 2, 0, 1);
            push((int'(wdata) << 2) | 1, 1, 0);
            push(int'(wdata) << 2, 2, 0);
          end
          m_idle = 0; m_ph = 0; m_cnt = 0;
        end
      end else begin
        bit adv, ab;
        int k;
        adv = 0; ab = 0; k = q_kind[m_ph];
        if (k == 0) begin
          if (m_cnt + 1 >= q_n[m_ph]) adv = 1;
        end else if (k == 2) begin
          if (!ack) adv = 1; else if (m_cnt + 1 >= m_lim) ab = 1;
        end else begin
          if (ack) begin adv = 1; if (k == 3) m_rdata = phy_val(m_addr); end
          else if (m_cnt + 1 >= m_lim) ab = 1;
        end
        if (ab) begin
          m_idle = 1; m_done = 1; m_err = 1;
        end else if (adv) begin
          m_ph++; m_cnt = 0;
          if (m_ph == q_kind.size()) begin m_idle = 1; m_done = 1; end
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 word", 32'(cr_out), m_idle ? 0 : q_word[m_ph]);
      chk("R9 busy", 32'(busy), 32'(!m_idle));
      chk("R10 done", 32'(done), 32'(m_done));
      chk("R8 err", 32'(err), 32'(m_err));
      chk("R11 rdata", 32'(rdata), m_rdata);
    end
    if (mode == 1) ack = 1'b0;
    else if (mode == 2) ack = 1'b1;
    else begin
      bit strb;
      strb = cr_out[19] | cr_out[18] | cr_out[1] | cr_out[0];
      if (strb && !ack) begin
        if (rc >= dly_r) begin
          ack = 1'b1; rc = 0;
          if (cr_out[19]) cap_addr = int'(cr_out[17:2]);
          if (cr_out[18]) cap_data = int'(cr_out[17:2]);
          if (cr_out[0])  begin commit = cap_data; commits++; end
        end else rc++;
      end else if (!strb && ack) begin
        if (rc >= dly_f) begin ack = 1'b0; rc = 0; end else rc++;
      end else rc = 0;
    end
  end

  task automatic access(input bit w, input int a, input int d, input int lim,
                        output int bcyc, output bit e);
    @(negedge clk);
    start = 1'b1; wr = w; addr = 16'(a); wdata = 16'(d); tmo = 16'(lim);
    @(negedge clk);
    start = 1'b0;
    bcyc = 0;
    while (!done) begin
      if (busy) bcyc++;
      @(negedge clk);
    end
    e = err;
  endtask

  initial begin
    fork
      begin : stim
        int  bc;
        bit  e;
        int  saved;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 word", 32'(cr_out), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 rdata", 32'(rdata), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // write, fast PHY
        access(1, 16'h1234, 16'hBEEF, 50, bc, e);
        chk("R3 captured addr", cap_addr, 16'h1234);
        chk("R5 captured data", cap_data, 16'hBEEF);
        chk("R6 committed", commit, 16'hBEEF);
        chk("R10 no err", 32'(e), 0);
        chk("R11 rdata after write", 32'(rdata), 0);

        // read, slow PHY
        dly_r = 3; dly_f = 2;
        access(0, 16'h0042, 0, 50, bc, e);
        chk("R4 rdata", 32'(rdata), phy_val(16'h0042));

        // range ends
        dly_r = 1; dly_f = 0;
        access(1, 16'hFFFF, 16'hFFFF, 50, bc, e);
        chk("R12 addr max", cap_addr, 16'hFFFF);
        chk("R12 data max", commit, 16'hFFFF);
        access(1, 16'h0000, 16'h0000, 50, bc, e);
        chk("R12 addr min", cap_addr, 0);
        chk("R12 data min", commit, 0);
        access(0, 16'hFFFF, 0, 50, bc, e);
        chk("R12 read max", 32'(rdata), phy_val(16'hFFFF));

        // start while busy
        saved = commits;
        @(negedge clk);
        start = 1'b1; wr = 1'b0; addr = 16'h0777; tmo = 16'd50;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; wr = 1'b1; addr = 16'h0999; wdata = 16'h5555;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R9 busy after", 32'(busy), 0);
        chk("R9 addr kept", cap_addr, 16'h0777);
        chk("R9 no write", commits, saved);
        chk("R11 read value", 32'(rdata), phy_val(16'h0777));

        // timeouts
        saved = int'(rdata);
        mode = 1;
        access(0, 16'h0100, 0, 5, bc, e);
        chk("R8 mute err", 32'(e), 1);
        chk("R8 mute cycles", bc, 7);
        chk("R11 kept after abort", 32'(rdata), saved);
        access(1, 16'h0101, 16'h0F0F, 0, bc, e);
        chk("R8 zero limit cycles", bc, 3);
        mode = 2;
        access(1, 16'h0102, 16'h00FF, 3, bc, e);
        chk("R8 stuck err", 32'(e), 1);
        chk("R8 stuck cycles", bc, 6);
        chk("R2 word after abort", 32'(cr_out), 0);
        mode = 0; ack = 1'b0;
        repeat (2) @(negedge clk);
        access(0, 16'h0033, 0, 20, bc, e);
        chk("R4 recovery read", 32'(rdata), phy_val(16'h0033));
        chk("R10 recovery err", 32'(e), 0);
        repeat (3) @(negedge clk);
      end
      begin : wdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule